// File: doc/BRIEF.md
# BCD Clock Calendar With Hundredths

This block is the counting core of a real-time clock. A single-cycle enable pulse arriving at 100 Hz advances a chain of packed-BCD fields: hundredths, seconds, minutes, hours, day of week, date, month and year. Each field carries into the next when it wraps. The date field wraps at the length of the current month, and February takes 29 days in years divisible by four.

The hour field runs in 24-hour form or in 12-hour form with an AM/PM flag. A control bit inside the hour byte selects the form. The day-of-week byte also holds two control bits. One of them stops all counting. The other is stored for a reset-input policy that is handled outside this block.

A byte-wide write port lets the serial transfer engine load any one of the eight bytes. All eight bytes are presented on one flat bus so that the engine can shift them out.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the bytes read hundredths 00, seconds 00, minutes 00, hour 00 (24-hour form), day byte 01, date 01, month 01, year 00.
- R2: Byte 0 counts hundredths 00 to 99. Its upper nibble is tenths and its lower nibble is hundredths. On the tick after 99 it returns to 00 and advances seconds (byte 1). Seconds and minutes (byte 2) each count 00 to 59 and carry onward when they wrap.
- R3: The chain advances only on a tick while bit 5 of byte 4 is 0. While that bit is 1, ticks leave every byte unchanged.
- R4: When bit 7 of byte 3 is 0 (24-hour form), the hour counts 00 to 23 with bits 5:4 as tens. The step from 23 to 00 advances the day of week and the date.
- R5: When bit 7 of byte 3 is 1 (12-hour form), bit 5 is PM and bit 4 is the tens digit. The count steps 11 AM to 12 PM, then 12 to 01 with the flag kept. The step 11 PM to 12 AM advances the day of week and the date.
- R6: Bits 2:0 of byte 4 hold the day of week, 1 to 7, and the count returns from 7 to 1. It advances together with the date at midnight, and bits 5 and 4 keep their values when it does.
- R7: The date (byte 5) counts from 01 up to the month length: 31, or 30 for months 04, 06, 09 and 11. It then returns to 01 and advances the month (byte 6).
- R8: February has 29 days when the year BCD value is divisible by 4 (00 included) and 28 days otherwise.
- R9: Month 12 wraps to 01 and advances the year (byte 7). Year 99 wraps to 00 and changes nothing else.
- R10: When `wr_en` is high, `wr_data` is stored at the next edge into the byte chosen by `wr_sel`. The load wins over a tick in the same cycle, and the loaded byte gives no carry in that cycle.
- R11: Reserved bits always read 0: byte 1 bit 7, byte 2 bit 7, byte 3 bit 6, byte 4 bits 7, 6 and 3, byte 5 bits 7 and 6, and byte 6 bits 7 to 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_100hz | input | 1 | One-cycle enable at 100 Hz |
| wr_en | input | 1 | Byte load strobe |
| wr_sel | input | 3 | Index of the byte to load, 0 to 7 |
| wr_data | input | 8 | Byte value to load |
| time_regs | output | 64 | Byte i on bits 8i+7:8i |

## Verification
The assertions check several rules on every cycle. A field that receives neither a load nor an increment holds its value. A load lands exactly as written, apart from reserved bits. The stop bit freezes every byte while no load is pending. The 11-to-12 step in 12-hour form flips the PM flag. A wrapped year reads 00.

Some behaviour can only be shown by the bench's directed scenarios, because it needs chosen calendar states as its starting point. This covers the month-length table, the leap-year rule, the ripple of carries at midnight and at year end, the 12-hour sequence around noon and midnight, and the priority of a load over a tick arriving in the same cycle.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NUM_BYTES = 8;
  localparam int SEL_W     = $clog2(NUM_BYTES);

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  function automatic logic leap_year(input logic [7:0] yr);
    logic odd_tens;
    odd_tens = yr[4];
    if (odd_tens) return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    else          return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] yr);
    logic [7:0] r;
    case (mon)
      8'h02:                      r = leap_year(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field #(
  parameter logic [7:0] MIN_VAL = 8'h00,
  parameter logic [7:0] KEEP    = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inc,
  input  logic       ld,
  input  logic [7:0] ld_val,
  input  logic [7:0] lim,
  output logic [7:0] val,
  output logic       carry
);
  import rtc_pkg::*;

  logic [7:0] val_q, val_d;
  logic       at_top;

  assign at_top = (val_q >= lim);
  assign carry  = inc && !ld && at_top;

  always_comb begin
    val_d = val_q;
    if (ld)       val_d = ld_val & KEEP;
    else if (inc) val_d = at_top ? MIN_VAL : (bcd_inc(val_q) & KEEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          val_q <= MIN_VAL;
    else if (ld || inc)  val_q <= val_d;
  end

  assign val = val_q;

  AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (val_q == ($past(ld_val) & KEEP))); // R10
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !inc) |=> $stable(val_q)); // R3
endmodule

// File: rtl/rtc_hour_field.sv
module rtc_hour_field (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inc,
  input  logic       ld,
  input  logic [7:0] ld_val,
  output logic [7:0] val,
  output logic       carry
);
  import rtc_pkg::*;

  localparam logic [7:0] KEEP = 8'hBF;

  logic [7:0] hr_q, hr_d;
  logic       mode12, pm;
  logic [7:0] low5_inc;
  logic       wrap;

  assign mode12   = hr_q[7];
  assign pm       = hr_q[5];
  assign low5_inc = bcd_inc({3'b000, hr_q[4:0]});

  always_comb begin
    hr_d = hr_q;
    wrap = 1'b0;
    if (ld) begin
      hr_d = ld_val & KEEP;
    end else if (inc) begin
      if (mode12) begin
        if (hr_q[4:0] == 5'h11) begin
          hr_d = {1'b1, 1'b0, ~pm, 5'h12};
          wrap = pm;
        end else if (hr_q[4:0] >= 5'h12) begin
          hr_d = {1'b1, 1'b0, pm, 5'h01};
        end else begin
          hr_d = {1'b1, 1'b0, pm, low5_inc[4:0]};
        end
      end else begin
        if (hr_q[5:0] >= 6'h23) begin
          hr_d = 8'h00;
          wrap = 1'b1;
        end else begin
          hr_d = bcd_inc({2'b00, hr_q[5:0]});
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hr_q <= 8'h00;
    else if (ld || inc) hr_q <= hr_d;
  end

  assign val   = hr_q;
  assign carry = wrap;

  AST_NOON_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !ld && hr_q[7] && hr_q[4:0] == 5'h11) |=> (hr_q[5] != $past(hr_q[5]))); // R5
  AST_HOUR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !ld) |=> $stable(hr_q)); // R3
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_100hz,
  input  logic        wr_en,
  input  logic [2:0]  wr_sel,
  input  logic [7:0]  wr_data,
  output logic [63:0] time_regs
);
  import rtc_pkg::*;

  localparam logic [7:0] DAY_KEEP = 8'h37;

  logic [NUM_BYTES-1:0] ld_vec;
  logic [7:0] hund_v, sec_v, min_v, hr_v, day_q, day_d, date_v, mon_v, yr_v;
  logic       c_hund, c_sec, c_min, c_hr, c_date, c_mon, c_yr;
  logic       run;
  logic [7:0] date_lim;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_BYTES; gi++) begin : g_ld
      assign ld_vec[gi] = wr_en && (wr_sel == SEL_W'(gi));
    end
  endgenerate

  assign run      = tick_100hz && !day_q[5];
  assign date_lim = month_last(mon_v, yr_v);

  rtc_bcd_field #(.MIN_VAL(8'h00), .KEEP(8'hFF)) u_hund (
    .clk(clk), .rst_n(rst_n), .inc(run), .ld(ld_vec[0]), .ld_val(wr_data),
    .lim(8'h99), .val(hund_v), .carry(c_hund));

  rtc_bcd_field #(.MIN_VAL(8'h00), .KEEP(8'h7F)) u_sec (
    .clk(clk), .rst_n(rst_n), .inc(c_hund), .ld(ld_vec[1]), .ld_val(wr_data),
    .lim(8'h59), .val(sec_v), .carry(c_sec));

  rtc_bcd_field #(.MIN_VAL(8'h00), .KEEP(8'h7F)) u_min (
    .clk(clk), .rst_n(rst_n), .inc(c_sec), .ld(ld_vec[2]), .ld_val(wr_data),
    .lim(8'h59), .val(min_v), .carry(c_min));

  rtc_hour_field u_hour (
    .clk(clk), .rst_n(rst_n), .inc(c_min), .ld(ld_vec[3]), .ld_val(wr_data),
    .val(hr_v), .carry(c_hr));

  always_comb begin
    day_d = day_q;
    if (ld_vec[4])  day_d = wr_data & DAY_KEEP;
    else if (c_hr)  day_d = {day_q[7:3], (day_q[2:0] >= 3'd7) ? 3'd1 : day_q[2:0] + 3'd1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 day_q <= 8'h01;
    else if (ld_vec[4] || c_hr) day_q <= day_d;
  end

  rtc_bcd_field #(.MIN_VAL(8'h01), .KEEP(8'h3F)) u_date (
    .clk(clk), .rst_n(rst_n), .inc(c_hr), .ld(ld_vec[5]), .ld_val(wr_data),
    .lim(date_lim), .val(date_v), .carry(c_date));

  rtc_bcd_field #(.MIN_VAL(8'h01), .KEEP(8'h1F)) u_mon (
    .clk(clk), .rst_n(rst_n), .inc(c_date), .ld(ld_vec[6]), .ld_val(wr_data),
    .lim(8'h12), .val(mon_v), .carry(c_mon));

  rtc_bcd_field #(.MIN_VAL(8'h00), .KEEP(8'hFF)) u_year (
    .clk(clk), .rst_n(rst_n), .inc(c_mon), .ld(ld_vec[7]), .ld_val(wr_data),
    .lim(8'h99), .val(yr_v), .carry(c_yr));

  assign time_regs = {yr_v, mon_v, date_v, day_q, hr_v, min_v, sec_v, hund_v};

  AST_STOP_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (day_q[5] && !wr_en) |=> $stable(time_regs)); // R3
  AST_YEAR_WRAPS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    c_yr |=> (yr_v == 8'h00)); // R9
  AST_DAY_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (c_hr && !ld_vec[4]) |=> (day_q[5:4] == $past(day_q[5:4]))); // R6
endmodule

// File: tb/rtc_calendar_core_tb.sv
module rtc_calendar_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_100hz = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = 3'd0;
  logic [7:0]  wr_data = 8'h00;
  logic [63:0] time_regs;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rtc_calendar_core u_dut (
    .clk(clk), .rst_n(rst_n), .tick_100hz(tick_100hz), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .time_regs(time_regs));

  function automatic logic [7:0] rb(input int idx);
    return time_regs[8*idx +: 8];
  endfunction

  task automatic check(input string req, input int idx, input logic [7:0] exp);
    n_chk++;
    if (rb(idx) !== exp) begin
      n_bad++;
      $display("FAIL %s byte%0d actual=%02h expected=%02h", req, idx, rb(idx), exp);
    end
  endtask

  task automatic load(input int idx, input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'(idx); wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load_tick(input int idx, input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'(idx); wr_data = v; tick_100hz = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick_100hz = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      tick_100hz = 1'b1;
      @(negedge clk);
      tick_100hz = 1'b0;
    end
  endtask

  task automatic edge_of_day();
    load(0, 8'h99); load(1, 8'h59); load(2, 8'h59);
  endtask

  task automatic t_reset();
    check("R1", 0, 8'h00); check("R1", 1, 8'h00); check("R1", 2, 8'h00);
    check("R1", 3, 8'h00); check("R1", 4, 8'h01); check("R1", 5, 8'h01);
    check("R1", 6, 8'h01); check("R1", 7, 8'h00);
  endtask

  task automatic t_low_chain();
    ticks(7);
    check("R2", 0, 8'h07);
    load(0, 8'h99); load(1, 8'h59); load(2, 8'h10);
    ticks(1);
    check("R2", 0, 8'h00); check("R2", 1, 8'h00); check("R2", 2, 8'h11);
    load(0, 8'h09); ticks(1);
    check("R2", 0, 8'h10);
  endtask

  task automatic t_stop();
    load(0, 8'h20); load(4, 8'h21);
    ticks(5);
    check("R3", 0, 8'h20);
    load(4, 8'h01); ticks(2);
    check("R3", 0, 8'h22);
  endtask

  task automatic t_24h();
    load(3, 8'h09); load(0, 8'h99); load(1, 8'h59); load(2, 8'h59);
    ticks(1);
    check("R4", 3, 8'h10);
    load(3, 8'h23); load(4, 8'h17); load(5, 8'h15); load(6, 8'h03);
    edge_of_day(); ticks(1);
    check("R4", 3, 8'h00); check("R6", 4, 8'h11); check("R4", 5, 8'h16);
  endtask

  task automatic t_12h();
    load(5, 8'h10); load(4, 8'h03);
    load(3, 8'h91); edge_of_day(); ticks(1);
    check("R5", 3, 8'hB2); check("R5", 5, 8'h10);
    edge_of_day(); ticks(1);
    check("R5", 3, 8'hA1);
    load(3, 8'hB1); edge_of_day(); ticks(1);
    check("R5", 3, 8'h92); check("R5", 5, 8'h11); check("R6", 4, 8'h04);
    load(3, 8'h00);
  endtask

  task automatic t_month_len();
    load(3, 8'h23); load(6, 8'h04); load(5, 8'h30); edge_of_day(); ticks(1);
    check("R7", 5, 8'h01); check("R7", 6, 8'h05);
    load(3, 8'h23); load(6, 8'h01); load(5, 8'h30); edge_of_day(); ticks(1);
    check("R7", 5, 8'h31);
    load(3, 8'h23); edge_of_day(); ticks(1);
    check("R7", 5, 8'h01); check("R7", 6, 8'h02);
  endtask

  task automatic t_leap();
    load(7, 8'h24); load(6, 8'h02); load(5, 8'h28); load(3, 8'h23); edge_of_day(); ticks(1);
    check("R8", 5, 8'h29); check("R8", 6, 8'h02);
    load(7, 8'h23); load(6, 8'h02); load(5, 8'h28); load(3, 8'h23); edge_of_day(); ticks(1);
    check("R8", 5, 8'h01); check("R8", 6, 8'h03);
    load(7, 8'h00); load(6, 8'h02); load(5, 8'h29); load(3, 8'h23); edge_of_day(); ticks(1);
    check("R8", 5, 8'h01); check("R8", 6, 8'h03);
  endtask

  task automatic t_year_end();
    load(7, 8'h99); load(6, 8'h12); load(5, 8'h31); load(4, 8'h02); load(3, 8'h23);
    edge_of_day(); ticks(1);
    check("R9", 7, 8'h00); check("R9", 6, 8'h01); check("R9", 5, 8'h01);
    check("R9", 4, 8'h03); check("R9", 3, 8'h00);
  endtask

  task automatic t_load_wins();
    load(1, 8'h10); load(0, 8'h99);
    load_tick(0, 8'h05);
    check("R10", 0, 8'h05); check("R10", 1, 8'h10);
    load(0, 8'h98);
    load_tick(1, 8'h33);
    check("R10", 1, 8'h33); check("R10", 0, 8'h99);
  endtask

  task automatic t_zero_bits();
    load(1, 8'hFF); check("R11", 1, 8'h7F);
    load(2, 8'hFF); check("R11", 2, 8'h7F);
    load(3, 8'hFF); check("R11", 3, 8'hBF);
    load(4, 8'hFF); check("R11", 4, 8'h37);
    load(5, 8'hFF); check("R11", 5, 8'h3F);
    load(6, 8'hFF); check("R11", 6, 8'h1F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_low_chain();
    t_stop();
    t_24h();
    t_12h();
    t_month_len();
    t_leap();
    t_year_end();
    t_load_wins();
    t_zero_bits();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule